// File: doc/BRIEF.md
# ADC Conversion Group Sequencer

This block chooses which analog input the converter samples next. Two channel lists are held as configuration: a regular list of up to sixteen slots and a short inserted list of up to four slots. Each slot is a 5-bit channel number, so any of the twenty multiplexed inputs (0 to 19) can be named. A software or external trigger starts one pass through a list. The inserted list wins at every decision point, so a short urgent pass is slotted between two regular conversions. The regular pass then continues from where it left off.

Conversion requests leave on a valid/ready stream. The request carries the channel number and a group tag. The converter acknowledges completion with a one-cycle `conv_done`. The sequencer reports each finished conversion with an end-of-conversion pulse, and the end of a pass with an end-of-group pulse. While `en` is low the block is held cleared. After `en` rises, triggers wait out a programmable start-up delay. A calibration request occupies the block for a fixed number of cycles, and its busy flag clears by itself.

Stream rules: once `conv_valid` is high, `conv_ch` and `conv_grp` stay fixed until a rising clock edge sees `conv_ready` high. The converter may hold `conv_ready` low for any number of cycles. After the handshake, no new request is raised until `conv_done` arrives. `conv_ready` is ignored while `conv_valid` is low, and `conv_done` is ignored unless a conversion is in flight.

Top module: `adcseq_top`

## Requirements
- R1: While `en` is low, `conv_valid`, `eoc`, `eog` and `cal_busy` are low one cycle later, and triggers and `cal_req` are ignored. Any pass in progress is discarded and does not resume when `en` returns.
- R2: When `en` rises, the delay count is loaded from `startup_dly` and then counts down once per cycle. Triggers that arrive while the count is non-zero are ignored.
- R3: In scan mode (`scan_mode`=1), a regular trigger (`reg_sw_trig` or `reg_ext_trig`) makes the block convert regular slots 0 up to `reg_len` in ascending order, which is `reg_len`+1 conversions.
- R4: In scan mode, an inserted trigger (`inj_sw_trig` or `inj_ext_trig`) makes the block convert inserted slots 3-`inj_len` up to 3 in ascending order. The inserted list is right-aligned, so the last slot is always used.
- R5: In single mode (`scan_mode`=0), a regular pass converts only regular slot 0 and an inserted pass converts only inserted slot 3, whatever the length fields hold.
- R6: A request is raised one cycle after the sequencer becomes free with a group pending. It follows the stream rules above. A `conv_done` that arrives while no conversion is in flight has no effect.
- R7: When both groups are pending at a decision point, the inserted group is issued first. A regular pass that was interrupted resumes at its next slot.
- R8: A trigger for a group that is still mid-pass is dropped, not queued. The pass continues unchanged.
- R9: `eoc` pulses for one cycle in the cycle after each accepted `conv_done`, with `done_grp` giving the group. `eog` pulses in the same cycle when that conversion was the last slot of its pass.
- R10: `cal_req` is accepted only when the block is enabled, past start-up, and has no pass pending or in flight. `cal_busy` then stays high for exactly CAL_CYCLES cycles and clears by itself. Triggers are ignored while it is high.
- R11: Slot i of a list sits at bits [5i+4:5i] of `reg_list` or `inj_list`. `conv_grp`/`done_grp` encode 0 for regular and 1 for inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Block enable; low holds the sequencer cleared |
| startup_dly | input | 8 | Start-up delay in cycles after `en` rises |
| scan_mode | input | 1 | 1: walk whole lists; 0: single slot per pass |
| reg_list | input | 80 | Sixteen 5-bit regular channel slots |
| reg_len | input | 4 | Regular pass length minus one |
| inj_list | input | 20 | Four 5-bit inserted channel slots |
| inj_len | input | 2 | Inserted pass length minus one |
| reg_sw_trig | input | 1 | Software trigger, regular group |
| reg_ext_trig | input | 1 | External trigger, regular group |
| inj_sw_trig | input | 1 | Software trigger, inserted group |
| inj_ext_trig | input | 1 | External trigger, inserted group |
| cal_req | input | 1 | Calibration request pulse |
| conv_valid | output | 1 | Conversion request valid |
| conv_ready | input | 1 | Converter accepts the request |
| conv_ch | output | 5 | Channel of the request |
| conv_grp | output | 1 | Group of the request (0 regular, 1 inserted) |
| conv_done | input | 1 | Converter finished the accepted request |
| eoc | output | 1 | End-of-conversion pulse |
| eog | output | 1 | End-of-group pulse |
| done_grp | output | 1 | Group of the conversion that just ended |
| cal_busy | output | 1 | Calibration in progress |

## Verification
A slot pointer that went wrong shows up at the ports as a wrong `conv_ch` on the very next request. It also shows as a miscounted pass, which is visible as `eog` arriving one conversion early or late. A priority or group-latch fault appears as a `conv_grp` mismatch within one cycle of the sequencer going free. A stuck delay or calibration counter appears as a request raised, or withheld, a cycle away from where the reference expects it. The reference model is compared against the ports on every clock. Any of these faults is therefore caught in the first cycle it changes an output.

// File: rtl/adcseq_pkg.sv
`timescale 1ns/1ps
package adcseq_pkg;
  localparam int CH_W = 5;

  typedef enum logic {
    GRP_REG = 1'b0,
    GRP_INJ = 1'b1
  } grp_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_CONV = 2'd2
  } phase_e;
endpackage

// File: rtl/adcseq_slotctl.sv
`timescale 1ns/1ps
// Per-group slot tracker: holds the active flag and the current slot pointer.
module adcseq_slotctl #(
  parameter int LEN_W       = 4,
  parameter bit RIGHT_ALIGN = 1'b0,
  localparam int SLOTS      = 1 << LEN_W,
  localparam int LIST_W     = SLOTS * adcseq_pkg::CH_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic [LIST_W-1:0]           list,
  input  logic [LEN_W-1:0]            len,
  input  logic                        scan,
  input  logic                        start,
  input  logic                        adv,
  output logic                        act,
  output logic [adcseq_pkg::CH_W-1:0] ch,
  output logic                        last
);
  import adcseq_pkg::*;

  localparam logic [LEN_W-1:0] TOP_IDX = {LEN_W{1'b1}};

  logic [LEN_W-1:0] idx;
  logic [LEN_W-1:0] first_idx;
  logic [LEN_W-1:0] last_idx;
  logic [CH_W-1:0]  slot_ch [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign slot_ch[s] = list[s*CH_W +: CH_W];
  end

  if (RIGHT_ALIGN) begin : g_right
    assign first_idx = scan ? (TOP_IDX - len) : TOP_IDX;
    assign last_idx  = TOP_IDX;
  end else begin : g_left
    assign first_idx = '0;
    assign last_idx  = scan ? len : '0;
  end

  assign ch   = slot_ch[idx];
  assign last = (idx == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      idx <= '0;
    end else if (clr) begin
      act <= 1'b0;
      idx <= '0;
    end else if (start && !act) begin
      act <= 1'b1;
      idx <= first_idx;
    end else if (adv && act) begin
      if (last) act <= 1'b0;
      else      idx <= idx + LEN_W'(1);
    end
  end

  // R8: the gate never offers a start to a group that is mid-pass
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !act);

  // R3: a non-final completion moves the pointer one slot on and keeps the pass open
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (act && adv && !last && !clr) |=> (act && idx == $past(idx) + LEN_W'(1)));
endmodule

// File: rtl/adcseq_gate.sv
`timescale 1ns/1ps
// Enable, start-up delay, calibration timer and trigger qualification.
module adcseq_gate #(
  parameter int DLY_W      = 8,
  parameter int CAL_CYCLES = 8,
  localparam int CAL_W     = $clog2(CAL_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DLY_W-1:0] startup_dly,
  input  logic             trig_reg,
  input  logic             trig_inj,
  input  logic             cal_req,
  input  logic             reg_act,
  input  logic             inj_act,
  input  logic             fsm_idle,
  output logic             clr,
  output logic             start_reg,
  output logic             start_inj,
  output logic             cal_busy
);
  logic [DLY_W-1:0] wait_cnt;
  logic [CAL_W-1:0] cal_cnt;
  logic             open_q;
  logic             cal_go;

  assign clr       = !en;
  assign open_q    = en && (wait_cnt == '0) && !cal_busy;
  assign start_reg = open_q && trig_reg && !reg_act;
  assign start_inj = open_q && trig_inj && !inj_act;
  assign cal_go    = open_q && cal_req && fsm_idle && !reg_act && !inj_act
                     && !start_reg && !start_inj;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wait_cnt <= '0;
    else if (!en)              wait_cnt <= startup_dly;
    else if (wait_cnt != '0)   wait_cnt <= wait_cnt - DLY_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_busy <= 1'b0;
      cal_cnt  <= '0;
    end else if (!en) begin
      cal_busy <= 1'b0;
      cal_cnt  <= '0;
    end else if (cal_busy) begin
      if (cal_cnt == CAL_W'(1)) cal_busy <= 1'b0;
      cal_cnt <= cal_cnt - CAL_W'(1);
    end else if (cal_go) begin
      cal_busy <= 1'b1;
      cal_cnt  <= CAL_W'(CAL_CYCLES);
    end
  end

  // R1: a low enable reloads the delay and cancels calibration
  a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!cal_busy && wait_cnt == $past(startup_dly)));

  // R10: the final count of a calibration releases the busy flag
  a_r10_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cal_busy && cal_cnt == CAL_W'(1)) |=> !cal_busy);
endmodule

// File: rtl/adcseq_arb.sv
`timescale 1ns/1ps
// Group arbiter and request/convert phase machine.
module adcseq_arb (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        reg_act,
  input  logic                        inj_act,
  input  logic [adcseq_pkg::CH_W-1:0] reg_ch,
  input  logic [adcseq_pkg::CH_W-1:0] inj_ch,
  input  logic                        reg_last,
  input  logic                        inj_last,
  input  logic                        conv_ready,
  input  logic                        conv_done,
  output logic                        conv_valid,
  output logic [adcseq_pkg::CH_W-1:0] conv_ch,
  output logic                        conv_grp,
  output logic                        reg_adv,
  output logic                        inj_adv,
  output logic                        eoc,
  output logic                        eog,
  output logic                        done_grp,
  output logic                        fsm_idle
);
  import adcseq_pkg::*;

  phase_e          ph;
  grp_e            cur_grp;
  grp_e            end_grp;
  logic [CH_W-1:0] cur_ch;
  logic            fin;
  logic            fin_last;

  assign conv_valid = (ph == PH_REQ);
  assign conv_ch    = cur_ch;
  assign conv_grp   = cur_grp;
  assign done_grp   = end_grp;
  assign fsm_idle   = (ph == PH_IDLE);
  assign fin        = (ph == PH_CONV) && conv_done;
  assign reg_adv    = fin && (cur_grp == GRP_REG);
  assign inj_adv    = fin && (cur_grp == GRP_INJ);
  assign fin_last   = (cur_grp == GRP_INJ) ? inj_last : reg_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cur_grp <= GRP_REG;
      cur_ch  <= '0;
      end_grp <= GRP_REG;
      eoc     <= 1'b0;
      eog     <= 1'b0;
    end else if (clr) begin
      ph  <= PH_IDLE;
      eoc <= 1'b0;
      eog <= 1'b0;
    end else begin
      eoc <= fin;
      eog <= fin && fin_last;
      if (fin) end_grp <= cur_grp;
      case (ph)
        PH_IDLE: begin
          if (inj_act) begin
            cur_grp <= GRP_INJ;
            cur_ch  <= inj_ch;
            ph      <= PH_REQ;
          end else if (reg_act) begin
            cur_grp <= GRP_REG;
            cur_ch  <= reg_ch;
            ph      <= PH_REQ;
          end
        end
        PH_REQ:  if (conv_ready) ph <= PH_CONV;
        PH_CONV: if (conv_done)  ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R6: a waiting request keeps its payload
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && !conv_ready && !clr) |=> (conv_valid && $stable(conv_ch) && $stable(conv_grp)));

  // R7: a pending inserted pass takes the next request
  a_r7_inj_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE && inj_act && !clr) |=> (conv_valid && conv_grp == GRP_INJ));

  // R9: end of group only coincides with an end of conversion
  a_r9_eog_in_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    eog |-> eoc);

  // R9: every end-of-conversion follows a done from the converter
  a_r9_eoc_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> $past(conv_done));
endmodule

// File: rtl/adcseq_top.sv
`timescale 1ns/1ps
module adcseq_top #(
  parameter int REG_LEN_W  = 4,
  parameter int INJ_LEN_W  = 2,
  parameter int DLY_W      = 8,
  parameter int CAL_CYCLES = 8,
  localparam int REG_LIST_W = (1 << REG_LEN_W) * adcseq_pkg::CH_W,
  localparam int INJ_LIST_W = (1 << INJ_LEN_W) * adcseq_pkg::CH_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic [DLY_W-1:0]            startup_dly,
  input  logic                        scan_mode,
  input  logic [REG_LIST_W-1:0]       reg_list,
  input  logic [REG_LEN_W-1:0]        reg_len,
  input  logic [INJ_LIST_W-1:0]       inj_list,
  input  logic [INJ_LEN_W-1:0]        inj_len,
  input  logic                        reg_sw_trig,
  input  logic                        reg_ext_trig,
  input  logic                        inj_sw_trig,
  input  logic                        inj_ext_trig,
  input  logic                        cal_req,
  output logic                        conv_valid,
  input  logic                        conv_ready,
  output logic [adcseq_pkg::CH_W-1:0] conv_ch,
  output logic                        conv_grp,
  input  logic                        conv_done,
  output logic                        eoc,
  output logic                        eog,
  output logic                        done_grp,
  output logic                        cal_busy
);
  import adcseq_pkg::*;

  logic            clr, start_reg, start_inj, fsm_idle;
  logic            reg_act, inj_act, reg_last, inj_last, reg_adv, inj_adv;
  logic [CH_W-1:0] reg_ch, inj_ch;

  adcseq_gate #(.DLY_W(DLY_W), .CAL_CYCLES(CAL_CYCLES)) u_gate (
    .clk(clk), .rst_n(rst_n), .en(en), .startup_dly(startup_dly),
    .trig_reg(reg_sw_trig || reg_ext_trig), .trig_inj(inj_sw_trig || inj_ext_trig),
    .cal_req(cal_req), .reg_act(reg_act), .inj_act(inj_act), .fsm_idle(fsm_idle),
    .clr(clr), .start_reg(start_reg), .start_inj(start_inj), .cal_busy(cal_busy)
  );

  adcseq_slotctl #(.LEN_W(REG_LEN_W), .RIGHT_ALIGN(1'b0)) u_reg_slots (
    .clk(clk), .rst_n(rst_n), .clr(clr), .list(reg_list), .len(reg_len),
    .scan(scan_mode), .start(start_reg), .adv(reg_adv),
    .act(reg_act), .ch(reg_ch), .last(reg_last)
  );

  adcseq_slotctl #(.LEN_W(INJ_LEN_W), .RIGHT_ALIGN(1'b1)) u_inj_slots (
    .clk(clk), .rst_n(rst_n), .clr(clr), .list(inj_list), .len(inj_len),
    .scan(scan_mode), .start(start_inj), .adv(inj_adv),
    .act(inj_act), .ch(inj_ch), .last(inj_last)
  );

  adcseq_arb u_arb (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .reg_act(reg_act), .inj_act(inj_act), .reg_ch(reg_ch), .inj_ch(inj_ch),
    .reg_last(reg_last), .inj_last(inj_last),
    .conv_ready(conv_ready), .conv_done(conv_done),
    .conv_valid(conv_valid), .conv_ch(conv_ch), .conv_grp(conv_grp),
    .reg_adv(reg_adv), .inj_adv(inj_adv), .eoc(eoc), .eog(eog),
    .done_grp(done_grp), .fsm_idle(fsm_idle)
  );

  // R1: a low enable silences requests and completion pulses
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!conv_valid && !eoc && !eog));
endmodule

// File: tb/adcseq_top_tb_top.sv
`timescale 1ns/1ps
module adcseq_top_tb_top;
  localparam int CAL = 8;

  logic        clk = 1'b0;
  logic        rst_n, en, scan_mode, cal_req;
  logic [7:0]  startup_dly;
  logic [79:0] reg_list;
  logic [3:0]  reg_len;
  logic [19:0] inj_list;
  logic [1:0]  inj_len;
  logic        reg_sw_trig, reg_ext_trig, inj_sw_trig, inj_ext_trig;
  logic        conv_valid, conv_grp, eoc, eog, done_grp, cal_busy;
  logic [4:0]  conv_ch;
  logic        conv_ready = 1'b0;
  logic        conv_done  = 1'b0;

  always #2.5 clk = ~clk;

  adcseq_top #(.CAL_CYCLES(CAL)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .startup_dly(startup_dly), .scan_mode(scan_mode),
    .reg_list(reg_list), .reg_len(reg_len), .inj_list(inj_list), .inj_len(inj_len),
    .reg_sw_trig(reg_sw_trig), .reg_ext_trig(reg_ext_trig),
    .inj_sw_trig(inj_sw_trig), .inj_ext_trig(inj_ext_trig), .cal_req(cal_req),
    .conv_valid(conv_valid), .conv_ready(conv_ready), .conv_ch(conv_ch),
    .conv_grp(conv_grp), .conv_done(conv_done), .eoc(eoc), .eog(eog),
    .done_grp(done_grp), .cal_busy(cal_busy)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag   = "R1";

  task automatic cmp(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cnt = 0, m_cal = 0, m_calcnt = 0, m_ph = 0, m_grp = 0, m_ch = 0;
  int m_eoc = 0, m_eog = 0, m_dgrp = 0;
  int rq[$];
  int iq[$];
  bit m_live = 1'b0;

  function automatic int rslot(int s);
    return int'(reg_list[s*5 +: 5]);
  endfunction
  function automatic int islot(int s);
    return int'(inj_list[s*5 +: 5]);
  endfunction

  always @(posedge clk) begin : model
    int ract, iact, open_now, idle_now, tr, ti, cgo;
    if (!rst_n) begin
      m_live = 1'b0; m_cnt = 0; m_cal = 0; m_calcnt = 0; m_ph = 0;
      m_eoc = 0; m_eog = 0; rq.delete(); iq.delete();
    end else begin
      m_live = 1'b1;
      if (!en) begin
        m_cnt = int'(startup_dly); m_cal = 0; m_calcnt = 0; m_ph = 0;
        m_eoc = 0; m_eog = 0; rq.delete(); iq.delete();
      end else begin
        ract     = (rq.size() > 0);
        iact     = (iq.size() > 0);
        open_now = (m_cnt == 0) && (m_cal == 0);
        tr       = open_now && (reg_sw_trig || reg_ext_trig) && !ract;
        ti       = open_now && (inj_sw_trig || inj_ext_trig) && !iact;
        idle_now = (m_ph == 0) && !ract && !iact;
        cgo      = open_now && cal_req && idle_now && !tr && !ti;
        m_eoc = 0; m_eog = 0;
        case (m_ph)
          0: if (iact) begin m_grp = 1; m_ch = iq[0]; m_ph = 1; end
             else if (ract) begin m_grp = 0; m_ch = rq[0]; m_ph = 1; end
          1: if (conv_ready) m_ph = 2;
          default: if (conv_done) begin
            m_eoc = 1; m_dgrp = m_grp; m_ph = 0;
            if (m_grp == 1) begin m_eog = (iq.size() == 1); void'(iq.pop_front()); end
            else            begin m_eog = (rq.size() == 1); void'(rq.pop_front()); end
          end
        endcase
        if (tr) begin
          if (scan_mode) for (int s = 0; s <= int'(reg_len); s++) rq.push_back(rslot(s));
          else rq.push_back(rslot(0));
        end
        if (ti) begin
          if (scan_mode) for (int s = 3 - int'(inj_len); s <= 3; s++) iq.push_back(islot(s));
          else iq.push_back(islot(3));
        end
        if (m_cnt != 0) m_cnt--;
        if (m_cal != 0) begin
          if (m_calcnt == 1) m_cal = 0;
          m_calcnt--;
        end else if (cgo) begin
          m_cal = 1; m_calcnt = CAL;
        end
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (m_live && rst_n) begin
      cmp("conv_valid", conv_valid, int'(m_ph == 1));
      if (conv_valid && m_ph == 1) begin
        cmp("conv_ch", conv_ch, m_ch);
        cmp("conv_grp", conv_grp, m_grp);
      end
      cmp("eoc", eoc, m_eoc);
      cmp("eog", eog, m_eog);
      cmp("cal_busy", cal_busy, m_cal);
      if (eoc && m_eoc != 0) cmp("done_grp", done_grp, m_dgrp);
    end
  end

  // ---------------- converter model ----------------
  bit cv_busy = 1'b0;
  int cv_wait = 0;
  bit stress  = 1'b0;
  bit spur    = 1'b0;
  int cyc     = 0;
  int hs_log[$];
  int exp_log[$];

  always @(negedge clk) begin
    cyc++;
    conv_done = 1'b0;
    if (cv_busy) begin
      if (cv_wait == 0) begin conv_done = 1'b1; cv_busy = 1'b0; end
      else cv_wait--;
    end else if (spur && (cyc % 7 == 0)) begin
      conv_done = 1'b1;
    end
    conv_ready = !cv_busy && (stress ? (cyc % 3 == 0) : 1'b1);
    if (!cv_busy && conv_valid && conv_ready) begin
      cv_busy = 1'b1;
      cv_wait = stress ? 4 : 2;
      hs_log.push_back(int'(conv_ch));
    end
  end

  // ---------------- helpers ----------------
  task automatic trig(int which);
    case (which)
      0: reg_sw_trig  = 1'b1;
      1: reg_ext_trig = 1'b1;
      2: inj_sw_trig  = 1'b1;
      default: inj_ext_trig = 1'b1;
    endcase
    @(negedge clk);
    reg_sw_trig = 1'b0; reg_ext_trig = 1'b0; inj_sw_trig = 1'b0; inj_ext_trig = 1'b0;
  endtask

  task automatic wait_quiet();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (m_ph == 0 && rq.size() == 0 && iq.size() == 0 && !cv_busy) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_log(string what);
    n_cmp++;
    if (hs_log.size() != exp_log.size()) begin
      n_bad++;
      $display("FAIL %s %s length: actual %0d expected %0d", tag, what, hs_log.size(), exp_log.size());
    end else begin
      foreach (exp_log[i]) if (hs_log[i] != exp_log[i]) begin
        n_bad++;
        $display("FAIL %s %s entry %0d: actual %0d expected %0d", tag, what, i, hs_log[i], exp_log[i]);
        break;
      end
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R6 watchdog: actual hung expected finished");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    int cal_hi;
    rst_n = 1'b0; en = 1'b0; startup_dly = 8'd0; scan_mode = 1'b1; cal_req = 1'b0;
    reg_len = 4'd0; inj_len = 2'd0;
    reg_sw_trig = 1'b0; reg_ext_trig = 1'b0; inj_sw_trig = 1'b0; inj_ext_trig = 1'b0;
    for (int s = 0; s < 16; s++) reg_list[s*5 +: 5] = 5'((s * 3 + 1) % 20);
    for (int s = 0; s < 4; s++)  inj_list[s*5 +: 5] = 5'(19 - s);
    repeat (3) @(negedge clk);

    tag = "R1";  // reset state
    cmp("reset conv_valid", conv_valid, 0);
    cmp("reset eoc", eoc, 0);
    cmp("reset cal_busy", cal_busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    tag = "R2";  // triggers inside the start-up window are ignored
    startup_dly = 8'd6;
    @(negedge clk);
    hs_log.delete();
    en = 1'b1;
    for (int k = 0; k < 4; k++) trig(k);
    repeat (8) @(negedge clk);
    cmp("requests during startup", hs_log.size(), 0);

    tag = "R3";  // scan regular pass, software trigger
    reg_len = 4'd5; hs_log.delete(); exp_log.delete();
    for (int s = 0; s <= 5; s++) exp_log.push_back((s * 3 + 1) % 20);
    trig(0); wait_quiet(); check_log("regular order");

    tag = "R11";  // length-one regular pass via external trigger
    reg_len = 4'd0; hs_log.delete(); exp_log.delete(); exp_log.push_back(1);
    trig(1); wait_quiet(); check_log("slot 0 field");

    tag = "R4";  // right-aligned inserted pass
    inj_len = 2'd2; hs_log.delete(); exp_log.delete();
    for (int s = 1; s <= 3; s++) exp_log.push_back(19 - s);
    trig(3); wait_quiet(); check_log("inserted order");
    inj_len = 2'd3; hs_log.delete(); exp_log.delete();
    for (int s = 0; s <= 3; s++) exp_log.push_back(19 - s);
    trig(2); wait_quiet(); check_log("inserted full");

    tag = "R5";  // single mode
    scan_mode = 1'b0; reg_len = 4'd7; inj_len = 2'd2;
    hs_log.delete(); exp_log.delete(); exp_log.push_back(1);
    trig(0); wait_quiet(); check_log("single regular");
    hs_log.delete(); exp_log.delete(); exp_log.push_back(16);
    trig(2); wait_quiet(); check_log("single inserted");
    scan_mode = 1'b1;

    tag = "R7";  // inserted pass interrupts a long regular pass
    reg_len = 4'd15; inj_len = 2'd1; hs_log.delete();
    trig(1); repeat (7) @(negedge clk); trig(2);
    wait_quiet();
    cmp("total conversions", hs_log.size(), 18);

    tag = "R8";  // re-trigger of a busy group is dropped
    hs_log.delete();
    trig(0); repeat (10) @(negedge clk); trig(1); repeat (5) @(negedge clk); trig(0);
    wait_quiet();
    cmp("regular conversions", hs_log.size(), 16);

    tag = "R6";  // back-pressure and stray done pulses
    stress = 1'b1; spur = 1'b1; reg_len = 4'd4; inj_len = 2'd3; hs_log.delete();
    trig(0); repeat (3) @(negedge clk); trig(3);
    wait_quiet();
    cmp("stressed conversions", hs_log.size(), 9);
    stress = 1'b0; spur = 1'b0;

    tag = "R9";  // end-of-group on several lengths
    reg_len = 4'd2; trig(0); wait_quiet();
    inj_len = 2'd0; trig(3); wait_quiet();

    tag = "R10";  // calibration length and trigger blocking
    hs_log.delete();
    cal_req = 1'b1; @(negedge clk); cal_req = 1'b0;
    cal_hi = 0;
    for (int k = 0; k < 20; k++) begin
      if (cal_busy) cal_hi++;
      if (k == 2) trig(0); else @(negedge clk);
    end
    cmp("cal_busy cycles", cal_hi, CAL);
    cmp("requests during calibration", hs_log.size(), 0);

    tag = "R1";  // disable mid-pass discards the pass
    reg_len = 4'd15; trig(0); repeat (12) @(negedge clk);
    en = 1'b0; startup_dly = 8'd0;
    repeat (3) @(negedge clk);
    cmp("conv_valid while off", conv_valid, 0);
    hs_log.delete();
    en = 1'b1;
    repeat (20) @(negedge clk);
    cmp("no resumed pass", hs_log.size(), 0);
    reg_len = 4'd3; trig(0); wait_quiet();
    cmp("pass after re-enable", hs_log.size(), 4);

    finish_run();
  end
endmodule